// File: doc/BRIEF.md
# Cosine-Sum Window Generator

This block produces, one sample per enabled clock, the coefficients of a cosine-sum window: w[n] = c0 − c1·cos(2πn/N) + c2·cos(4πn/N), with N = 2^PHASE_W. No coefficient memory is used. A free-running phase counter feeds two fully pipelined shift-add rotators, one per harmonic. Each rotator folds its phase into the right half-plane and turns the phase into a cosine. A two-stage multiply-add then weights the cosines with the three coefficients on the input ports, and rounds and saturates the result.

The same hardware yields Hann, Hamming or a three-term Blackman-Harris shape, and the caller chooses among them through the three weights. Weights and output are unsigned fractions with an LSB of 2^-DATA_W. The block is meant to sit beside an FFT data path, and its valid strobe tells the downstream multiplier when to apply the current window value. The output width should be at least PHASE_W bits.

Top module: `cosine_window_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `win_smp` is cleared to 0 and `win_vld` to 0. The phase counter returns to sample index 0, so the first valid sample after reset is w[0].
- R2: The first `win_vld` pulse after reset is produced by enabled clock edge number DATA_W+3. In other words, exactly DATA_W+2 enabled edges precede it.
- R3: The valid samples repeat with a period of 2^PHASE_W. The m-th valid sample after reset equals w[m mod 2^PHASE_W].
- R4: Each valid sample equals c0 − c1·cos(2πn/N) + c2·cos(4πn/N) to within 6 LSB. Here c_k = wt_k / 2^DATA_W, and the output is also read as a fraction of 2^DATA_W.
- R5: A clock edge with `en` low is ignored. `win_smp` keeps its value, `win_vld` is 0 after that edge, and the sample sequence resumes where it stopped.
- R6: A weighted sum at or above 1.0 saturates `win_smp` to all ones.
- R7: A negative weighted sum clamps `win_smp` to 0.
- R8: Once the pipeline has filled, every enabled edge produces one `win_vld` pulse, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable for the counter and the whole pipeline |
| wt0 | input | DATA_W | Constant-term weight, unsigned fraction |
| wt1 | input | DATA_W | First-harmonic weight (subtracted) |
| wt2 | input | DATA_W | Second-harmonic weight (added) |
| win_smp | output | DATA_W | Window sample, unsigned fraction |
| win_vld | output | 1 | One-cycle strobe: a new window sample is present |

## Verification
The bench builds the block with PHASE_W = 10 and DATA_W = 16, so one full 1024-sample period and its wrap fit into a short run. Every sample is compared with a real-valued cosine model. Because the window is short, both the fold boundaries at ±π/2 and the doubled phase of the second harmonic are crossed many times per run. A 16-bit output leaves enough headroom to push the weighted sum past both saturation limits with extreme weights. Random enable gaps exercise the stall behaviour and the valid timing at every pipeline depth.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

  localparam real CWG_PI = 3.14159265358979323846;

  // arctangent by power series, valid for |x| <= 0.5
  function automatic real atan_series(input real x);
    real acc;
    real pw;
    acc = 0.0;
    pw  = x;
    for (int k = 0; k < 60; k++) begin
      if (k % 2 == 0) acc = acc + pw / real'(2 * k + 1);
      else            acc = acc - pw / real'(2 * k + 1);
      pw = pw * x * x;
    end
    return acc;
  endfunction

  // atan(2^-i) on a scale where 2^(w-1) equals pi
  function automatic longint angle_units(input int i, input int w);
    real a;
    real x;
    real sc;
    x = 1.0;
    for (int j = 0; j < i; j++) x = x / 2.0;
    if (i == 0) a = CWG_PI / 4.0;
    else        a = atan_series(x);
    sc = 1.0;
    for (int j = 0; j < w - 1; j++) sc = sc * 2.0;
    return $rtoi(a / CWG_PI * sc + 0.5);
  endfunction

  // reciprocal rotator gain for n iterations, 1.0 == 2^(w-2)
  function automatic longint inv_gain_units(input int n, input int w);
    real k2;
    real p;
    real s;
    real sc;
    k2 = 1.0;
    p  = 1.0;
    for (int i = 0; i < n; i++) begin
      k2 = k2 / (1.0 + p);
      p  = p / 4.0;
    end
    s = 1.0;
    for (int i = 0; i < 60; i++) s = 0.5 * (s + k2 / s);
    sc = 1.0;
    for (int j = 0; j < w - 2; j++) sc = sc * 2.0;
    return $rtoi(s * sc + 0.5);
  endfunction

endpackage

// File: rtl/cwg_cordic_cos.sv
module cwg_cordic_cos
  import cwg_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD   = 4,
  parameter int PHASE_W = 10
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            en,
  input  logic [PHASE_W-1:0]              phase,
  output logic signed [DATA_W+GUARD-1:0]  cos_o
);
  localparam int XW  = DATA_W + GUARD;
  localparam int NST = DATA_W - 1;
  localparam logic signed [XW-1:0] X0   = XW'(inv_gain_units(NST, XW));
  localparam logic signed [XW-1:0] ONE  = XW'(longint'(1) <<< (XW - 2));
  localparam logic signed [XW-1:0] CTOL = ONE + XW'(4 * NST);
  localparam logic signed [XW-1:0] ZTOL = XW'(angle_units(NST - 1, XW) + NST);

  // input stage: map phase onto pi-scaled angle, fold to right half-plane
  logic [XW-1:0]         z_full;
  logic                  fold;
  logic signed [XW-1:0]  z_in_q;
  logic                  neg_in_q;

  assign z_full = {phase, {(XW-PHASE_W){1'b0}}};
  assign fold   = z_full[XW-1] ^ z_full[XW-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      z_in_q   <= '0;
      neg_in_q <= 1'b0;
    end else if (en) begin
      z_in_q   <= fold ? {~z_full[XW-1], z_full[XW-2:0]} : z_full;
      neg_in_q <= fold;
    end
  end

  for (genvar i = 0; i < NST; i++) begin : g_st
    localparam logic signed [XW-1:0] ANG = XW'(angle_units(i, XW));
    logic signed [XW-1:0] xi, yi, zi;
    logic                 ni;
    logic signed [XW-1:0] xo, yo, zo;
    logic                 no;

    if (i == 0) begin : g_head
      assign xi = X0;
      assign yi = '0;
      assign zi = z_in_q;
      assign ni = neg_in_q;
    end else begin : g_link
      assign xi = g_st[i-1].xo;
      assign yi = g_st[i-1].yo;
      assign zi = g_st[i-1].zo;
      assign ni = g_st[i-1].no;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        xo <= '0;
        yo <= '0;
        zo <= '0;
        no <= 1'b0;
      end else if (en) begin
        if (zi[XW-1]) begin
          xo <= xi + (yi >>> i);
          yo <= yi - (xi >>> i);
          zo <= zi + ANG;
        end else begin
          xo <= xi - (yi >>> i);
          yo <= yi + (xi >>> i);
          zo <= zi - ANG;
        end
        no <= ni;
      end
    end
  end

  logic signed [XW-1:0] x_last;
  logic signed [XW-1:0] z_last;
  logic                 n_last;
  assign x_last = g_st[NST-1].xo;
  assign z_last = g_st[NST-1].zo;
  assign n_last = g_st[NST-1].no;

  always_ff @(posedge clk) begin
    if (rst)     cos_o <= '0;
    else if (en) cos_o <= n_last ? -x_last : x_last;
  end

  // R4: the rotation has driven the residual angle close to zero
  p_residual_small_r4: assert property (@(posedge clk) disable iff (rst)
    (z_last <= ZTOL) && (z_last >= -ZTOL));

  // R4: the cosine never exceeds unity by more than rounding slack
  p_cos_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (cos_o <= CTOL) && (cos_o >= -CTOL));

endmodule

// File: rtl/cwg_term_sum.sv
module cwg_term_sum #(
  parameter int DATA_W = 16,
  parameter int XW     = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [DATA_W-1:0]       wt0,
  input  logic [DATA_W-1:0]       wt1,
  input  logic [DATA_W-1:0]       wt2,
  input  logic signed [XW-1:0]    c1,
  input  logic signed [XW-1:0]    c2,
  output logic [DATA_W-1:0]       win_o
);
  localparam int PW = DATA_W + XW + 1;
  localparam int SW = PW + 2;
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (XW - 3);
  localparam logic signed [SW-1:0] MAXV = SW'({DATA_W{1'b1}});

  logic signed [DATA_W:0] w1s, w2s, w0s;
  logic signed [PW-1:0]   p1_q, p2_q;
  logic signed [SW-1:0]   acc;
  logic signed [SW-1:0]   rnd;
  logic [DATA_W-1:0]      sat;

  assign w0s = {1'b0, wt0};
  assign w1s = {1'b0, wt1};
  assign w2s = {1'b0, wt2};

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_q <= '0;
      p2_q <= '0;
    end else if (en) begin
      p1_q <= PW'(w1s) * PW'(c1);
      p2_q <= PW'(w2s) * PW'(c2);
    end
  end

  always_comb begin
    acc = (SW'(w0s) <<< (XW - 2)) - SW'(p1_q) + SW'(p2_q) + HALF;
    rnd = acc >>> (XW - 2);
    if (rnd < 0)         sat = '0;
    else if (rnd > MAXV) sat = '1;
    else                 sat = rnd[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     win_o <= '0;
    else if (en) win_o <= sat;
  end

endmodule

// File: rtl/cosine_window_gen.sv
module cosine_window_gen #(
  parameter int PHASE_W = 10,
  parameter int DATA_W  = 16,
  parameter int GUARD   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] wt0,
  input  logic [DATA_W-1:0] wt1,
  input  logic [DATA_W-1:0] wt2,
  output logic [DATA_W-1:0] win_smp,
  output logic              win_vld
);
  localparam int XW    = DATA_W + GUARD;
  localparam int NHARM = 2;
  localparam int LAT   = DATA_W + 2;   // enabled edges from counter to output
  localparam int FW    = $clog2(LAT + 1);

  logic [PHASE_W-1:0]   cnt_q;
  logic [FW-1:0]        fill_q;
  logic signed [XW-1:0] cos_v [1:NHARM];

  always_ff @(posedge clk) begin
    if (rst)     cnt_q <= '0;
    else if (en) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 1; k <= NHARM; k++) begin : g_harm
    logic [PHASE_W-1:0] ph;
    assign ph = PHASE_W'(cnt_q * PHASE_W'(k));
    cwg_cordic_cos #(
      .DATA_W (DATA_W),
      .GUARD  (GUARD),
      .PHASE_W(PHASE_W)
    ) u_rot (
      .clk  (clk),
      .rst  (rst),
      .en   (en),
      .phase(ph),
      .cos_o(cos_v[k])
    );
  end

  cwg_term_sum #(
    .DATA_W(DATA_W),
    .XW    (XW)
  ) u_sum (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .wt0  (wt0),
    .wt1  (wt1),
    .wt2  (wt2),
    .c1   (cos_v[1]),
    .c2   (cos_v[2]),
    .win_o(win_smp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q  <= '0;
      win_vld <= 1'b0;
    end else begin
      win_vld <= en && (fill_q == FW'(LAT));
      if (en && fill_q != FW'(LAT)) fill_q <= fill_q + 1'b1;
    end
  end

  // R1: leaving reset, the output is quiet
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!win_vld && win_smp == '0));

  // R5: a strobe only follows an enabled edge
  p_vld_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> $past(en));

  // R5: a disabled edge leaves the sample untouched
  p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(win_smp));

endmodule

// File: tb/cosine_window_gen_tb.sv
`timescale 1ns/1ps
module cosine_window_gen_tb;
  localparam int PHASE_W = 10;
  localparam int DATA_W  = 16;
  localparam int N       = 1 << PHASE_W;
  localparam int LAT     = DATA_W + 2;
  localparam int TOL     = 6;
  localparam int FULL    = (1 << DATA_W) - 1;
  localparam real PI     = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [DATA_W-1:0] wt0 = '0, wt1 = '0, wt2 = '0;
  logic [DATA_W-1:0] win_smp;
  logic              win_vld;

  int n_chk = 0;
  int n_fail = 0;
  int en_edges, idx, last_win;
  bit seen_vld, cur_en;

  always #2.5 clk = ~clk;

  cosine_window_gen #(.PHASE_W(PHASE_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .en(en), .wt0(wt0), .wt1(wt1), .wt2(wt2),
    .win_smp(win_smp), .win_vld(win_vld)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(input int n);
    real x;
    int  r;
    x = real'(wt0) - real'(wt1) * $cos(2.0 * PI * real'(n) / real'(N))
                   + real'(wt2) * $cos(4.0 * PI * real'(n) / real'(N));
    if (x < 0.0) return 0;
    r = $rtoi(x + 0.5);
    if (r > FULL) r = FULL;
    return r;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    en  = 1'b0;
    repeat (3) @(negedge clk);
    // R1: cleared state under reset
    chk(win_smp == '0, "R1 sample", int'(win_smp), 0);
    chk(win_vld == 1'b0, "R1 valid", int'(win_vld), 0);
    rst = 1'b0;
    en_edges = 0; idx = 0; seen_vld = 1'b0; cur_en = 1'b0; last_win = 0;
  endtask

  task automatic run(input int nsamp, input int pct, input string tag);
    int exp, d;
    bit exp_vld;
    while (idx < nsamp) begin
      cur_en = (($urandom % 100) < pct);
      en = cur_en;
      @(negedge clk);
      if (cur_en) en_edges++;
      exp_vld = cur_en && (en_edges > LAT);
      // R8 no gaps once full, R5 no strobe after an idle edge
      chk(win_vld == exp_vld, cur_en ? "R8 strobe" : "R5 strobe",
          int'(win_vld), int'(exp_vld));
      if (!cur_en) chk(int'(win_smp) == last_win, "R5 hold", int'(win_smp), last_win);
      if (win_vld && !seen_vld) begin
        seen_vld = 1'b1;
        chk(en_edges == LAT + 1, "R2 latency", en_edges, LAT + 1);
      end
      if (win_vld) begin
        exp = model(idx % N);
        d = int'(win_smp) - exp;
        if (d < 0) d = -d;
        chk(d <= TOL, (idx >= N) ? "R3 wrap" : tag, int'(win_smp), exp);
        idx++;
      end
      last_win = int'(win_smp);
    end
    en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: got 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // Hann, continuous enable, one period plus wrap (R4, R3)
    wt0 = 16'd32768; wt1 = 16'd32768; wt2 = 16'd0;
    do_reset();
    run(N + 24, 100, "R4 hann");
    // Hamming with random stalls (R4, R5)
    wt0 = 16'd35389; wt1 = 16'd30147; wt2 = 16'd0;
    do_reset();
    run(300, 50, "R4 hamming");
    // three-term Blackman-Harris, full period with stalls
    wt0 = 16'd27737; wt1 = 16'd32607; wt2 = 16'd5192;
    do_reset();
    run(N, 80, "R4 bh3");
    // upper saturation: 1 + cos(2x) >= 1 near n = 0 (R6)
    wt0 = 16'hFFFF; wt1 = 16'd0; wt2 = 16'hFFFF;
    do_reset();
    run(200, 90, "R6 saturate");
    // lower clamp: -cos(x) negative in the first quarter (R7)
    wt0 = 16'd0; wt1 = 16'hFFFF; wt2 = 16'd0;
    do_reset();
    run(300, 90, "R7 clamp");
    // random weights
    for (int t = 0; t < 3; t++) begin
      wt0 = DATA_W'($urandom % 65536);
      wt1 = DATA_W'($urandom % 32768);
      wt2 = DATA_W'($urandom % 32768);
      do_reset();
      run(200, 70, "R4 random");
    end
    // reset in the middle of a run restarts at sample 0 (R1)
    wt0 = 16'd32768; wt1 = 16'd32768; wt2 = 16'd0;
    do_reset();
    run(40, 100, "R4 pre-reset");
    do_reset();
    run(40, 100, "R1 restart");
    summary();
    $finish;
  end

endmodule